// File: doc/BRIEF.md
# Operating-System Timer with Cross-Domain Register Access

This block is a memory-mapped system timer. A 32-bit counter advances on every edge of a slow timer clock, about 3 MHz, while counting is enabled. It wraps to zero after its largest value. Four compare channels watch the counter, and each one raises its own status flag when the counter steps onto that channel's compare value. The interrupt line is asserted while any status flag is raised and its enable bit is set.

Software reaches the block through a simple register bus clocked by a faster bus clock. The counter and the compare values live in the timer domain, so software cannot touch them directly. A write to the counter or to a compare register is held on the bus side and carried across by a toggle/acknowledge handshake. A busy bit in the access-status word stays raised until the value has landed. To read the counter, software asks for a snapshot through the control word, polls a read-busy bit, and then reads the captured value. The remaining registers are plain bus-side registers and are accessed directly.

Top module: `ostimer_sync`

## Requirements
- R1: After reset, every compare register reads 0xFFFFFFFF. Status, interrupt enable, control and access status read 0, and `irq` is low.
- R2: A write to compare register n (offset 4*n, n = 0..3) sets access-status bit n, which later clears without further action. Reading the register then returns the written value.
- R3: A write to the counter (offset 0x10) sets access-status bit 4 until the value has reached the timer domain. While counting is stopped, a later snapshot returns exactly that value.
- R4: Writing the control word (offset 0x20) with bit 1 set requests a snapshot and sets access-status bit 5 (offset 0x24) until the captured count can be read at offset 0x10.
- R5: A write to a counter or compare register whose access-status bit is still set is ignored. That register keeps the earlier value.
- R6: Control bit 0 enables counting. While it is 1, successive snapshots increase. While it is 0, the count holds.
- R7: When the counter advances onto the value of compare register n, bit n of the status register (offset 0x14) becomes 1.
- R8: Writing the status register clears exactly the bits written as 1 and leaves the others unchanged.
- R9: `irq` is the OR over n of status bit n ANDed with bit n of the interrupt enable register (offset 0x1C). With the enable at 0, `irq` stays low even when a status bit is set.
- R10: The counter wraps modulo 2^32, and a compare value just past the wrap point still raises its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| rst_bus_n | input | 1 | Active-low reset, bus domain |
| clk_tmr | input | 1 | Slow timer clock |
| rst_tmr_n | input | 1 | Active-low reset, timer domain |
| bus_addr | input | 6 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, one bus cycle per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data, registered one cycle after the address |
| irq | output | 1 | Interrupt request, level |

## Verification
Read data is registered, so a read result is due one bus cycle after its address. The scoreboard arms its compare on the next rising edge and samples on the falling edge that follows. A busy bit is visible on the first read after its write. It clears only after two synchronizer flops and a capture register in the timer domain, and then two flops back, a window of several timer periods. A status bit rises two to three bus cycles after the timer edge on which the match occurs. The bench therefore polls the access-status and status words until the expected state appears, with a bounded retry count, and never waits a fixed delay. The exception is the `irq` output, which follows a status or enable change in the next bus cycle and is checked there.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;
    localparam int unsigned TMR_CNT_W   = 32;
    localparam int unsigned TMR_N_MATCH = 4;
    localparam int unsigned TMR_ADDR_W  = 6;

    // Register offsets (compare channel n sits at 4*n)
    localparam logic [TMR_ADDR_W-1:0] OFS_COUNT = 6'h10;
    localparam logic [TMR_ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [TMR_ADDR_W-1:0] OFS_IER   = 6'h1C;
    localparam logic [TMR_ADDR_W-1:0] OFS_CTRL  = 6'h20;
    localparam logic [TMR_ADDR_W-1:0] OFS_ACC   = 6'h24;

    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_SNAP_BIT = 1;
endpackage

// File: rtl/ostimer_sync2.sv
module ostimer_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = async_i;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.stable;
endmodule

// File: rtl/ostimer_tdom.sv
module ostimer_tdom
    import ostimer_pkg::*;
#(
    parameter int unsigned CNT_W   = TMR_CNT_W,
    parameter int unsigned N_MATCH = TMR_N_MATCH
) (
    input  logic                            clk_tmr,
    input  logic                            rst_tmr_n,
    input  logic [N_MATCH+1:0]              req_tgl_i,
    input  logic [CNT_W-1:0]                cnt_wr_i,
    input  logic [N_MATCH-1:0][CNT_W-1:0]   match_wr_i,
    input  logic                            run_i,
    output logic [N_MATCH+1:0]              ack_tgl_o,
    output logic [CNT_W-1:0]                snap_o,
    output logic [N_MATCH-1:0]              hit_tgl_o
);
    localparam int unsigned N_X      = N_MATCH + 2;
    localparam int unsigned IDX_CNT  = N_MATCH;
    localparam int unsigned IDX_SNAP = N_MATCH + 1;

    typedef struct packed {
        logic [N_X-1:0]                  seen;
        logic [CNT_W-1:0]                cnt;
        logic [N_MATCH-1:0][CNT_W-1:0]   match;
        logic [CNT_W-1:0]                snap;
        logic [N_MATCH-1:0]              hit;
    } td_t;

    td_t td_d, td_q;

    logic [N_X-1:0] req_s;
    logic           run_s;
    logic [N_X-1:0] fresh;
    logic [CNT_W-1:0] cnt_nxt;

    ostimer_sync2 #(.W(N_X + 1)) u_sync_in (
        .clk     (clk_tmr),
        .rst_n   (rst_tmr_n),
        .async_i ({run_i, req_tgl_i}),
        .sync_o  ({run_s, req_s})
    );

    assign fresh   = req_s ^ td_q.seen;
    assign cnt_nxt = td_q.cnt + 1'b1;

    always_comb begin
        td_d      = td_q;
        td_d.seen = req_s;
        if (run_s) td_d.cnt = cnt_nxt;
        if (fresh[IDX_CNT]) td_d.cnt = cnt_wr_i;
        for (int n = 0; n < int'(N_MATCH); n++) begin
            if (fresh[n]) td_d.match[n] = match_wr_i[n];
            if (run_s && !fresh[IDX_CNT] && cnt_nxt == td_q.match[n])
                td_d.hit[n] = ~td_q.hit[n];
        end
        if (fresh[IDX_SNAP]) td_d.snap = td_q.cnt;
    end

    always_ff @(posedge clk_tmr or negedge rst_tmr_n) begin
        if (!rst_tmr_n) begin
            td_q       <= '0;
            td_q.match <= '1;
        end else begin
            td_q <= td_d;
        end
    end

    assign ack_tgl_o = td_q.seen;
    assign snap_o    = td_q.snap;
    assign hit_tgl_o = td_q.hit;
endmodule

// File: rtl/ostimer_bus.sv
module ostimer_bus
    import ostimer_pkg::*;
#(
    parameter int unsigned CNT_W   = TMR_CNT_W,
    parameter int unsigned N_MATCH = TMR_N_MATCH
) (
    input  logic                            clk_bus,
    input  logic                            rst_bus_n,
    input  logic [TMR_ADDR_W-1:0]           addr_i,
    input  logic                            wr_en_i,
    input  logic [CNT_W-1:0]                wr_data_i,
    output logic [CNT_W-1:0]                rd_data_o,
    output logic                            irq_o,
    input  logic [N_MATCH+1:0]              ack_tgl_i,
    input  logic [N_MATCH-1:0]              hit_tgl_i,
    input  logic [CNT_W-1:0]                snap_i,
    output logic [N_MATCH+1:0]              req_tgl_o,
    output logic [CNT_W-1:0]                cnt_wr_o,
    output logic [N_MATCH-1:0][CNT_W-1:0]   match_wr_o,
    output logic                            run_o,
    output logic [N_MATCH+1:0]              busy_o,
    output logic [N_MATCH-1:0]              ier_o
);
    localparam int unsigned N_X      = N_MATCH + 2;
    localparam int unsigned IDX_CNT  = N_MATCH;
    localparam int unsigned IDX_SNAP = N_MATCH + 1;

    typedef struct packed {
        logic [N_MATCH-1:0][CNT_W-1:0]   match;
        logic [CNT_W-1:0]                cnt;
        logic [N_X-1:0]                  req;
        logic [N_MATCH-1:0]              stat;
        logic [N_MATCH-1:0]              ier;
        logic                            run;
        logic [N_MATCH-1:0]              hit_seen;
        logic [CNT_W-1:0]                rdata;
    } bs_t;

    bs_t bs_d, bs_q;

    logic [N_X-1:0]     ack_s;
    logic [N_MATCH-1:0] hit_s;
    logic [N_X-1:0]     busy;
    logic [CNT_W-1:0]   rd;

    ostimer_sync2 #(.W(N_X + N_MATCH)) u_sync_back (
        .clk     (clk_bus),
        .rst_n   (rst_bus_n),
        .async_i ({hit_tgl_i, ack_tgl_i}),
        .sync_o  ({hit_s, ack_s})
    );

    assign busy = bs_q.req ^ ack_s;

    always_comb begin
        bs_d          = bs_q;
        bs_d.hit_seen = hit_s;

        if (wr_en_i) begin
            for (int n = 0; n < int'(N_MATCH); n++) begin
                if (addr_i == TMR_ADDR_W'(4 * n) && !busy[n]) begin
                    bs_d.match[n] = wr_data_i;
                    bs_d.req[n]   = ~bs_q.req[n];
                end
            end
            case (addr_i)
                OFS_COUNT: if (!busy[IDX_CNT]) begin
                    bs_d.cnt          = wr_data_i;
                    bs_d.req[IDX_CNT] = ~bs_q.req[IDX_CNT];
                end
                OFS_STAT: bs_d.stat = bs_q.stat & ~wr_data_i[N_MATCH-1:0];
                OFS_IER:  bs_d.ier  = wr_data_i[N_MATCH-1:0];
                OFS_CTRL: begin
                    bs_d.run = wr_data_i[CTRL_RUN_BIT];
                    if (wr_data_i[CTRL_SNAP_BIT] && !busy[IDX_SNAP])
                        bs_d.req[IDX_SNAP] = ~bs_q.req[IDX_SNAP];
                end
                default: ;
            endcase
        end

        // a fresh match event wins over a simultaneous clear
        bs_d.stat = bs_d.stat | (hit_s ^ bs_q.hit_seen);

        rd = '0;
        for (int n = 0; n < int'(N_MATCH); n++)
            if (addr_i == TMR_ADDR_W'(4 * n)) rd = bs_q.match[n];
        case (addr_i)
            OFS_COUNT: rd = snap_i;
            OFS_STAT:  rd[N_MATCH-1:0] = bs_q.stat;
            OFS_IER:   rd[N_MATCH-1:0] = bs_q.ier;
            OFS_CTRL:  rd[CTRL_RUN_BIT] = bs_q.run;
            OFS_ACC:   rd[N_X-1:0] = busy;
            default: ;
        endcase
        bs_d.rdata = rd;
    end

    always_ff @(posedge clk_bus or negedge rst_bus_n) begin
        if (!rst_bus_n) begin
            bs_q       <= '0;
            bs_q.match <= '1;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign rd_data_o  = bs_q.rdata;
    assign irq_o      = |(bs_q.stat & bs_q.ier);
    assign req_tgl_o  = bs_q.req;
    assign cnt_wr_o   = bs_q.cnt;
    assign match_wr_o = bs_q.match;
    assign run_o      = bs_q.run;
    assign busy_o     = busy;
    assign ier_o      = bs_q.ier;
endmodule

// File: rtl/ostimer_sync.sv
module ostimer_sync
    import ostimer_pkg::*;
#(
    parameter int unsigned CNT_W   = TMR_CNT_W,
    parameter int unsigned N_MATCH = TMR_N_MATCH
) (
    input  logic                  clk_bus,
    input  logic                  rst_bus_n,
    input  logic                  clk_tmr,
    input  logic                  rst_tmr_n,
    input  logic [TMR_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr_en,
    input  logic [CNT_W-1:0]      bus_wr_data,
    output logic [CNT_W-1:0]      bus_rd_data,
    output logic                  irq
);
    localparam int unsigned N_X = N_MATCH + 2;

    logic [N_X-1:0]                req_tgl, ack_tgl, busy_w;
    logic [N_MATCH-1:0]            hit_tgl, ier_w;
    logic [CNT_W-1:0]              snap, cnt_wr;
    logic [N_MATCH-1:0][CNT_W-1:0] match_wr;
    logic                          run;

    ostimer_bus #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_bus (
        .clk_bus    (clk_bus),
        .rst_bus_n  (rst_bus_n),
        .addr_i     (bus_addr),
        .wr_en_i    (bus_wr_en),
        .wr_data_i  (bus_wr_data),
        .rd_data_o  (bus_rd_data),
        .irq_o      (irq),
        .ack_tgl_i  (ack_tgl),
        .hit_tgl_i  (hit_tgl),
        .snap_i     (snap),
        .req_tgl_o  (req_tgl),
        .cnt_wr_o   (cnt_wr),
        .match_wr_o (match_wr),
        .run_o      (run),
        .busy_o     (busy_w),
        .ier_o      (ier_w)
    );

    ostimer_tdom #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_tdom (
        .clk_tmr    (clk_tmr),
        .rst_tmr_n  (rst_tmr_n),
        .req_tgl_i  (req_tgl),
        .cnt_wr_i   (cnt_wr),
        .match_wr_i (match_wr),
        .run_i      (run),
        .ack_tgl_o  (ack_tgl),
        .snap_o     (snap),
        .hit_tgl_o  (hit_tgl)
    );
endmodule

// File: rtl/ostimer_chk.sv
module ostimer_chk
    import ostimer_pkg::*;
#(
    parameter int unsigned N_MATCH = TMR_N_MATCH
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [TMR_ADDR_W-1:0] addr,
    input logic                  wr_en,
    input logic                  snap_bit,
    input logic                  irq,
    input logic [N_MATCH+1:0]    busy,
    input logic [N_MATCH-1:0]    ier
);
    localparam int unsigned IDX_CNT  = N_MATCH;
    localparam int unsigned IDX_SNAP = N_MATCH + 1;

    for (genvar n = 0; n < int'(N_MATCH); n++) begin : g_ch
        // R2: an accepted compare write raises its busy bit
        assert_match_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == TMR_ADDR_W'(4 * n) && !busy[n]) |=> busy[n]);
        // R2 / R5: a busy bit only rises after a write to its own register
        assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[n]) |-> $past(wr_en && addr == TMR_ADDR_W'(4 * n)));
    end

    assert_count_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_COUNT && !busy[IDX_CNT]) |=> busy[IDX_CNT]);

    assert_snap_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL && snap_bit && !busy[IDX_SNAP]) |=> busy[IDX_SNAP]);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == '0) |-> !irq);
endmodule

bind ostimer_sync ostimer_chk #(.N_MATCH(N_MATCH)) u_chk (
    .clk      (clk_bus),
    .rst_n    (rst_bus_n),
    .addr     (bus_addr),
    .wr_en    (bus_wr_en),
    .snap_bit (bus_wr_data[1]),
    .irq      (irq),
    .busy     (busy_w),
    .ier      (ier_w)
);

// File: tb/ostimer_sync_bench.sv
module ostimer_sync_bench;
    logic        clk_bus = 0, clk_tmr = 0;
    logic        rst_bus_n = 0, rst_tmr_n = 0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr_en = 0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10  clk_bus = ~clk_bus;   // 50 MHz
    always #167 clk_tmr = ~clk_tmr;   // about 3 MHz

    ostimer_sync u_ostimer_sync (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_tmr(clk_tmr), .rst_tmr_n(rst_tmr_n),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_data(bus_rd_data), .irq(irq)
    );

    // scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic fire = 0, arm = 0;

    always @(posedge clk_bus) arm <= fire;

    always @(negedge clk_bus) begin
        if (arm) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rd_data !== e) begin
                fails++;
                $display("FAIL %s: actual=%h expected=%h", t, bus_rd_data, e);
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk_bus);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1;
        @(negedge clk_bus);
        bus_wr_en = 0;
    endtask

    task automatic peek(logic [5:0] a, output logic [31:0] v);
        @(negedge clk_bus);
        bus_addr = a;
        @(negedge clk_bus);
        v = bus_rd_data;
    endtask

    task automatic expect_rd(logic [5:0] a, logic [31:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk_bus);
        bus_addr = a; fire = 1;
        @(negedge clk_bus);
        fire = 0;
    endtask

    task automatic wait_acc_clear(int b, string tag);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            peek(6'h24, v);
            if (!v[b]) return;
        end
        check(0, tag, v, 32'h0);
    endtask

    task automatic wait_stat_set(int b, string tag);
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            peek(6'h14, v);
            if (v[b]) return;
        end
        check(0, tag, v, 32'h1 << b);
    endtask

    task automatic snapshot(bit run, output logic [31:0] v);
        wr(6'h20, {30'h0, 1'b1, run});
        wait_acc_clear(5, "R4 snapshot busy clear");
        peek(6'h10, v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] v, v1, v2;
        repeat (3) @(negedge clk_bus);
        rst_bus_n = 1; rst_tmr_n = 1;
        repeat (2) @(negedge clk_bus);

        // R1 reset state
        for (int n = 0; n < 4; n++) expect_rd(6'(4 * n), 32'hFFFF_FFFF, "R1 compare reset");
        expect_rd(6'h14, 32'h0, "R1 status reset");
        expect_rd(6'h1C, 32'h0, "R1 enable reset");
        expect_rd(6'h20, 32'h0, "R1 control reset");
        expect_rd(6'h24, 32'h0, "R1 access reset");
        check(irq == 1'b0, "R1 irq reset", {31'h0, irq}, 32'h0);

        // R2 compare write handshake
        wr(6'h04, 32'h1234_5678);
        peek(6'h24, v);
        check(v[1] == 1'b1, "R2 busy bit 1 set", v, 32'h2);
        wait_acc_clear(1, "R2 busy bit 1 clear");
        expect_rd(6'h04, 32'h1234_5678, "R2 compare readback");
        expect_rd(6'h24, 32'h0, "R2 access idle");

        // R5 write while busy is dropped
        wr(6'h08, 32'hAAAA_0001);
        wr(6'h08, 32'hBBBB_0002);
        wait_acc_clear(2, "R5 busy bit 2 clear");
        expect_rd(6'h08, 32'hAAAA_0001, "R5 busy write ignored");
        wr(6'h08, 32'hBBBB_0002);
        wait_acc_clear(2, "R5 busy bit 2 clear again");
        expect_rd(6'h08, 32'hBBBB_0002, "R5 later write accepted");

        // R3 counter write, R4 snapshot
        wr(6'h10, 32'h0000_1000);
        peek(6'h24, v);
        check(v[4] == 1'b1, "R3 busy bit 4 set", v, 32'h10);
        wait_acc_clear(4, "R3 busy bit 4 clear");
        wr(6'h20, 32'h2);
        peek(6'h24, v);
        check(v[5] == 1'b1, "R4 busy bit 5 set", v, 32'h20);
        wait_acc_clear(5, "R4 busy bit 5 clear");
        expect_rd(6'h10, 32'h0000_1000, "R3 counter value landed");

        // R6 counting on and off
        wr(6'h20, 32'h1);
        repeat (100) @(negedge clk_bus);
        snapshot(1, v1);
        repeat (300) @(negedge clk_bus);
        snapshot(1, v2);
        check(v2 > v1 && (v2 - v1) < 32'd200, "R6 counter advances", v2, v1);
        wr(6'h20, 32'h0);
        repeat (100) @(negedge clk_bus);
        snapshot(0, v1);
        repeat (200) @(negedge clk_bus);
        snapshot(0, v2);
        check(v2 == v1, "R6 counter holds when stopped", v2, v1);

        // R7 match, R9 masking
        wr(6'h10, 32'h0000_0100);
        wait_acc_clear(4, "R7 counter load");
        wr(6'h0C, 32'h0000_0108);
        wait_acc_clear(3, "R7 compare load");
        wr(6'h20, 32'h1);
        wait_stat_set(3, "R7 status bit 3");
        expect_rd(6'h14, 32'h8, "R7 only channel 3 matched");
        check(irq == 1'b0, "R9 irq masked", {31'h0, irq}, 32'h0);
        wr(6'h1C, 32'h8);
        check(irq == 1'b1, "R9 irq enabled", {31'h0, irq}, 32'h1);

        // R8 write-one-to-clear
        wr(6'h14, 32'h1);
        expect_rd(6'h14, 32'h8, "R8 other bit kept");
        wr(6'h14, 32'h8);
        expect_rd(6'h14, 32'h0, "R8 bit cleared");
        check(irq == 1'b0, "R9 irq drops after clear", {31'h0, irq}, 32'h0);

        // R10 wrap
        wr(6'h20, 32'h0);
        wr(6'h10, 32'hFFFF_FFF0);
        wait_acc_clear(4, "R10 counter load");
        wr(6'h00, 32'h0000_0003);
        wait_acc_clear(0, "R10 compare load");
        wr(6'h1C, 32'h1);
        wr(6'h20, 32'h1);
        wait_stat_set(0, "R10 status bit 0 after wrap");
        expect_rd(6'h14, 32'h1, "R10 only channel 0 matched");
        check(irq == 1'b1, "R10 irq after wrap", {31'h0, irq}, 32'h1);
        snapshot(1, v);
        check(v >= 32'd3 && v < 32'h100, "R10 count wrapped", v, 32'h3);

        repeat (4) @(negedge clk_bus);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
        finish_run();
    end
endmodule